// File: doc/BRIEF.md
# Prefetch Pollution Bloom Filter

This block estimates how much a hardware prefetcher is harming a cache by pushing out lines that demand traffic still needs. It keeps a one-bit-per-entry vector addressed by a short hash of the block address. The cache reports three kinds of events. The first is a prefetch fill that has just evicted a line brought in by a demand miss. The second is a prefetch request that has been serviced. The third is a demand miss. The first kind marks the victim's entry. The second unmarks the prefetched address. The third looks the vector up: a marked entry means the miss was probably caused by an earlier prefetch eviction.

Two saturating counters accumulate demand misses and the subset judged pollution-induced. On each interval pulse the block latches a three-level pollution class from the ratio of the two counters. It then halves both counters, so that older intervals fade without being forgotten at once. The filter contents persist across intervals. Aliasing between addresses that share an index is accepted by design, because the estimate only needs to be statistically useful.

Event inputs carry an address and are qualified by a valid bit. The block has no back-pressure and takes every event in the cycle it is presented, so no ready signal exists on the inputs. Each demand miss produces exactly one lookup result one cycle later on `resp_valid`/`resp_polluted`. The consumer must take it in that cycle, since no hold or ready is offered.

Top module: `pollution_filter`

## Requirements
- R1: The filter index of an address is addr[11:0] XOR addr[23:12] (for the default 12-bit index). Any two addresses with the same index share one entry.
- R2: An eviction event (`evict_valid`) marks the entry at the index of `evict_addr`. The mark is visible to a demand lookup from the next cycle.
- R3: A serviced-prefetch event (`svc_valid`) unmarks the entry at the index of `svc_addr` from the next cycle.
- R4: A demand miss (`miss_valid`) produces `resp_valid`=1 exactly one cycle later. `resp_polluted` equals the entry state before any update made in the miss's own cycle.
- R5: When an eviction and a serviced prefetch address the same index in one cycle, the entry ends up marked.
- R6: A demand lookup never changes the filter; a marked entry stays marked after any number of hits.
- R7: `demand_count` rises by one per demand miss and `pollute_count` by one per miss whose lookup is marked. Both saturate at 65535, and `pollute_count` never exceeds `demand_count`.
- R8: On `interval_tick`, `level` takes the class of the counter values held before the pulse: 0 (low) when demand is zero or pollute*16 < demand*2; 2 (high) when pollute*16 >= demand*8; else 1 (medium). `level` holds between pulses.
- R9: On `interval_tick` each counter becomes half its old value (rounded down) plus any increment from the same cycle. The filter contents are not changed by the pulse.
- R10: After reset every entry is unmarked, both counters are zero, `level` is 0 and `resp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evict_valid | input | 1 | A prefetch fill evicted a demand-fetched line |
| evict_addr | input | 32 | Block address of the evicted line |
| svc_valid | input | 1 | A prefetch request was serviced |
| svc_addr | input | 32 | Block address of the serviced prefetch |
| miss_valid | input | 1 | Demand miss lookup request |
| miss_addr | input | 32 | Block address of the demand miss |
| interval_tick | input | 1 | End-of-interval pulse |
| resp_valid | output | 1 | Lookup result valid, one cycle after a miss |
| resp_polluted | output | 1 | Lookup found the entry marked |
| demand_count | output | 16 | Running demand-miss count |
| pollute_count | output | 16 | Running pollution-miss count |
| level | output | 2 | Latched pollution class: 0 low, 1 medium, 2 high |

## Verification
Lookups are tried on unmarked addresses, on marked ones, and on the same address before and after a serviced prefetch. This tells the set and clear rules apart and shows that repeated hits leave a mark in place. A second address built to hash to the same entry separates true aliasing from a tag match. Same-cycle set/clear on one index is tried against set/clear on two distinct indices to confirm the priority rule. A long run of polluted misses reaches saturation. Interval pulses are issued at zero, low, medium and high ratios, and together with a miss in the same cycle, to tell the latched class, the halving and the retention of filter bits apart.

// File: rtl/pfp_pkg.sv
package pfp_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MED  = 2'd1,
    LVL_HIGH = 2'd2
  } poll_level_e;

endpackage

// File: rtl/pfp_hash.sv
module pfp_hash #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);

  // fold two adjacent index-wide slices of the block address
  assign idx = addr[IDX_W-1:0] ^ addr[2*IDX_W-1:IDX_W];

endmodule

// File: rtl/pfp_filter_array.sv
module pfp_filter_array #(
  parameter int IDX_W = 12,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_v,
  input  logic [IDX_W-1:0] set_i,
  input  logic             clr_v,
  input  logic [IDX_W-1:0] clr_i,
  input  logic [IDX_W-1:0] look_i,
  output logic             look_hit
);

  logic [ENTRIES-1:0] marks;

  // later assignment wins: set overrides a clear of the same entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      marks <= '0;
    end else begin
      if (clr_v) marks[clr_i] <= 1'b0;
      if (set_v) marks[set_i] <= 1'b1;
    end
  end

  assign look_hit = marks[look_i];

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_v |=> marks[$past(set_i)]);

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_v && !(set_v && set_i == clr_i)) |=> !marks[$past(clr_i)]);

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v && clr_v && set_i == clr_i) |=> marks[$past(set_i)]);

  assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(set_v && set_i == look_i) && !(clr_v && clr_i == look_i))
      |=> marks[$past(look_i)] == $past(look_hit));

endmodule

// File: rtl/pfp_sat_counter.sv
module pfp_sat_counter #(
  parameter int CNT_W = 16,
  localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             halve,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    base = halve ? (count >> 1) : count;
    nxt  = base;
    if (inc && base != MAX_VAL) nxt = base + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end

  assert_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!halve && inc && count == MAX_VAL) |=> count == MAX_VAL);

  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!halve && inc && count != MAX_VAL) |=> count == $past(count) + 1'b1);

  assert_halve_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halve |=> count == (($past(count) >> 1) + CNT_W'($past(inc))));

endmodule

// File: rtl/pfp_classifier.sv
module pfp_classifier
  import pfp_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DEN    = 16,
  parameter int LO_NUM = 2,
  parameter int HI_NUM = 8,
  localparam int PW    = CNT_W + 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] demand,
  input  logic [CNT_W-1:0] pollute,
  output poll_level_e      level
);

  logic [PW-1:0] scaled_p;
  logic [PW-1:0] lo_bound;
  logic [PW-1:0] hi_bound;
  poll_level_e   cls;

  assign scaled_p = PW'(pollute) * PW'(DEN);
  assign lo_bound = PW'(demand) * PW'(LO_NUM);
  assign hi_bound = PW'(demand) * PW'(HI_NUM);

  always_comb begin
    if (demand == '0)               cls = LVL_LOW;
    else if (scaled_p < lo_bound)   cls = LVL_LOW;
    else if (scaled_p >= hi_bound)  cls = LVL_HIGH;
    else                            cls = LVL_MED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    level <= LVL_LOW;
    else if (tick) level <= cls;
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(level));

  assert_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    level != 2'd3);

endmodule

// File: rtl/pollution_filter.sv
module pollution_filter
  import pfp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic              svc_valid,
  input  logic [ADDR_W-1:0] svc_addr,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              interval_tick,
  output logic              resp_valid,
  output logic              resp_polluted,
  output logic [CNT_W-1:0]  demand_count,
  output logic [CNT_W-1:0]  pollute_count,
  output logic [1:0]        level
);

  localparam int N_CNT = 2;

  logic [IDX_W-1:0] e_idx, s_idx, m_idx;
  logic             hit;
  logic [N_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_val [N_CNT];
  poll_level_e      lvl;

  pfp_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_ev (.addr(evict_addr), .idx(e_idx));
  pfp_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_sv (.addr(svc_addr),   .idx(s_idx));
  pfp_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_ms (.addr(miss_addr),  .idx(m_idx));

  pfp_filter_array #(.IDX_W(IDX_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .set_v(evict_valid), .set_i(e_idx),
    .clr_v(svc_valid),   .clr_i(s_idx),
    .look_i(m_idx),      .look_hit(hit)
  );

  // counter 0: all demand misses, counter 1: misses that found a mark
  assign cnt_inc[0] = miss_valid;
  assign cnt_inc[1] = miss_valid & hit;

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    pfp_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .inc(cnt_inc[g]), .halve(interval_tick),
      .count(cnt_val[g])
    );
  end

  assign demand_count  = cnt_val[0];
  assign pollute_count = cnt_val[1];

  pfp_classifier #(.CNT_W(CNT_W)) u_cls (
    .clk(clk), .rst_n(rst_n), .tick(interval_tick),
    .demand(cnt_val[0]), .pollute(cnt_val[1]), .level(lvl)
  );
  assign level = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid    <= 1'b0;
      resp_polluted <= 1'b0;
    end else begin
      resp_valid    <= miss_valid;
      resp_polluted <= miss_valid & hit;
    end
  end

  assert_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> resp_valid);

  assert_no_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_valid |=> !resp_valid);

  assert_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pollute_count <= demand_count);

endmodule

// File: tb/sim_pollution_filter.sv
`timescale 1ns/100ps
module sim_pollution_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evict_valid = 1'b0, svc_valid = 1'b0, miss_valid = 1'b0, interval_tick = 1'b0;
  logic [31:0] evict_addr = '0, svc_addr = '0, miss_addr = '0;
  logic        resp_valid, resp_polluted;
  logic [15:0] demand_count, pollute_count;
  logic [1:0]  level;

  always #2.5 clk = ~clk;

  pollution_filter u0 (
    .clk(clk), .rst_n(rst_n),
    .evict_valid(evict_valid), .evict_addr(evict_addr),
    .svc_valid(svc_valid), .svc_addr(svc_addr),
    .miss_valid(miss_valid), .miss_addr(miss_addr),
    .interval_tick(interval_tick),
    .resp_valid(resp_valid), .resp_polluted(resp_polluted),
    .demand_count(demand_count), .pollute_count(pollute_count),
    .level(level)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference state built from the requirements
  bit    ref_marks [4096];
  int    ref_dem = 0;
  int    ref_pol = 0;
  int    ref_lvl = 0;
  bit    exp_q [$];
  string tag_q [$];

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int hidx(input logic [31:0] a);  // R1
    return int'(a[11:0] ^ a[23:12]);
  endfunction

  function automatic int classify(input int d, input int p);  // R8
    if (d == 0) return 0;
    if (p * 16 < d * 2) return 0;
    if (p * 16 >= d * 8) return 2;
    return 1;
  endfunction

  // drive one cycle at a falling edge, predict, then check the counters one cycle on
  task automatic step(input bit ev, input logic [31:0] ea, input bit sv, input logic [31:0] sa,
                      input bit mv, input logic [31:0] ma, input bit tk, input string tag);
    bit pol;
    evict_valid = ev; evict_addr = ea;
    svc_valid = sv;   svc_addr = sa;
    miss_valid = mv;  miss_addr = ma;
    interval_tick = tk;
    pol = mv && ref_marks[hidx(ma)];
    if (mv) begin
      exp_q.push_back(pol);
      tag_q.push_back(tag);
    end
    if (tk) begin
      ref_lvl = classify(ref_dem, ref_pol);
      ref_dem = ref_dem >> 1;
      ref_pol = ref_pol >> 1;
    end
    if (mv && ref_dem < 65535) ref_dem++;
    if (pol && ref_pol < 65535) ref_pol++;
    if (sv) ref_marks[hidx(sa)] = 1'b0;
    if (ev) ref_marks[hidx(ea)] = 1'b1;   // R5: set applied last
    @(negedge clk);
    evict_valid = 1'b0; svc_valid = 1'b0; miss_valid = 1'b0; interval_tick = 1'b0;
    chk("R7", int'(demand_count), ref_dem, {tag, " demand_count"});
    chk("R7", int'(pollute_count), ref_pol, {tag, " pollute_count"});
    chk("R8", int'(level), ref_lvl, {tag, " level"});
  endtask

  task automatic miss(input logic [31:0] a, input string tag);
    step(0, '0, 0, '0, 1, a, 0, tag);
  endtask

  // monitor: pop one prediction per lookup result
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 unexpected response: actual=1 expected=0");
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk("R4", int'(resp_polluted), int'(e), {t, " resp_polluted"});
      end
    end
  end

  localparam logic [31:0] A  = 32'h0001_2345;  // index 0x357
  localparam logic [31:0] B  = 32'h000E_23B5;  // R1: also index 0x357
  localparam logic [31:0] C  = 32'h00AB_C111;
  localparam logic [31:0] D  = 32'h0000_0042;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", int'(demand_count), 0, "reset demand_count");
    chk("R10", int'(pollute_count), 0, "reset pollute_count");
    chk("R10", int'(level), 0, "reset level");
    chk("R10", int'(resp_valid), 0, "reset resp_valid");
    chk("R1", hidx(A), hidx(B), "alias pair index");

    miss(A, "R10 clean lookup");
    step(1, A, 0, '0, 0, '0, 0, "R2 evict A");
    miss(A, "R2 marked lookup");
    miss(A, "R6 repeat hit keeps mark");
    miss(A, "R6 third hit");
    miss(B, "R1 alias hit");
    // R4: lookup sees pre-update state in a same-cycle clear
    step(0, '0, 1, A, 1, A, 0, "R4 lookup with same-cycle clear");
    miss(A, "R3 cleared lookup");
    // R4: lookup with same-cycle set sees old clear state
    step(1, C, 0, '0, 1, C, 0, "R4 lookup with same-cycle set");
    miss(C, "R2 set visible next cycle");
    // R5 same index set and clear
    step(1, A, 1, B, 0, '0, 0, "R5 set vs clear same index");
    miss(A, "R5 set wins");
    // distinct indices: both act
    step(1, D, 1, C, 0, '0, 0, "R3 distinct set and clear");
    miss(C, "R3 C cleared");
    miss(D, "R2 D set");

    // R8/R9 pulses: high ratio, then halving to zero
    step(0, '0, 0, '0, 0, '0, 1, "R8 tick high");
    for (int i = 0; i < 5; i++) step(0, '0, 0, '0, 0, '0, 1, "R9 halve tick");
    chk("R8", ref_dem, 0, "bench demand drained");
    step(0, '0, 0, '0, 0, '0, 1, "R8 tick zero demand");
    miss(A, "R9 mark kept after ticks");
    for (int i = 0; i < 11; i++) miss(32'h0050_0000 + 32'(i), "R8 clean fill");
    miss(D, "R8 polluted fill");
    step(0, '0, 0, '0, 0, '0, 1, "R8 tick medium");
    for (int i = 0; i < 40; i++) miss(32'h0060_0000 + 32'(i), "R8 clean fill low");
    step(0, '0, 0, '0, 1, A, 1, "R9 tick with same-cycle miss");
    step(0, '0, 0, '0, 0, '0, 1, "R8 tick low");

    // R7 saturation
    for (int i = 0; i < 65600; i++) miss(A, "R7 saturate");
    chk("R7", int'(demand_count), 65535, "saturated demand");
    step(0, '0, 0, '0, 1, A, 1, "R9 tick at saturation");
    miss(D, "R9 D mark retained");

    repeat (3) @(negedge clk);
    chk("R4", exp_q.size(), 0, "pending responses");
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule